// File: doc/BRIEF.md
# Memory-Mapped Bridge to Legacy Display Ports and Mode Registers

This block sits behind a 4 KB memory-mapped window and turns each bus access into the byte-wide or index/data operations a legacy display controller expects. A small slice of the window mirrors the controller's byte-wide port range. Another slice reaches a bank of sixteen-bit mode-extension registers, which the controller reaches through an index register and a data register. The rest of the window reads as zero and ignores writes.

A request of one to four bytes is taken on a valid/ready handshake. While the request is being carried out, the block runs its sub-operations one per clock: ordered byte operations for the port range, or index-then-data pairs for the extension bank. It then presents the assembled little-endian read data on a response channel. The request channel has back-pressure: `req_ready` is high only when the block is idle. The response channel also has back-pressure: `rsp_valid` and `rsp_rdata` stay put until `rsp_ready` is seen high on a clock edge, and only then does `req_ready` return. Downstream read data (`lp_rdata`, `ext_rdata`) must be valid in the same cycle as the read strobe.

Top module: `disp_mmio_bridge`

## Requirements
- R1: `req_ready` is high only when idle. After a request is accepted it stays low until the response is taken. `rsp_valid` with `rsp_rdata` stays stable until `rsp_ready` is sampled high.
- R2: Window offsets 0x400 to 0x41F form the port range, and offset 0x400+n drives port address 0x3C0+n on `lp_addr`.
- R3: A request whose start offset is in the port range issues `req_len`+1 byte operations, one per cycle, at rising addresses from the start offset. Byte k writes `req_wdata[8k+7:8k]` or reads into `rsp_rdata[8k+7:8k]`. A byte whose address lies past 0x41F is not issued and reads as zero.
- R4: Offsets 0x500 to 0x515 form the extension range, and offset o selects register index (o-0x500)>>1, with 11 registers (index 0 to 10).
- R5: A request starting in the extension range runs one halfword operation for `req_len` 0 or 1, and two for `req_len` 2 or 3 (at o and o+2). Each operation is one cycle of `ext_idx_wr`, which updates `ext_idx`, then one cycle of `ext_data_wr`/`ext_data_rd` at that index. Halfword h uses `req_wdata[16h+15:16h]` and fills `rsp_rdata[16h+15:16h]`. An operation that falls outside the range issues no strobe and reads zero.
- R6: A request starting outside both ranges issues no downstream strobe and responds with zero read data.
- R7: Response bytes above lane `req_len` read as zero, and write bytes above lane `req_len` are treated as zero, so a one-byte extension write stores the byte zero-extended.
- R8: `rsp_valid` rises this many clock edges after the accepting edge (that edge not counted): `req_len`+1 for the port range, 2×(number of halfword operations) for the extension range, and 0 for an unmapped request, whose response is valid right after the accepting edge.
- R9: Reset leaves the block idle with `req_ready` high, `rsp_valid` low, `ext_idx` zero and every downstream strobe low.
- R10: At most one downstream strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 12 | Byte offset within the window |
| req_len | input | 2 | Access size minus one (0 to 3 means 1 to 4 bytes) |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Little-endian write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Little-endian read data, zero for writes |
| lp_wr | output | 1 | Port byte write strobe |
| lp_rd | output | 1 | Port byte read strobe |
| lp_addr | output | 10 | Port address |
| lp_wdata | output | 8 | Port write byte |
| lp_rdata | input | 8 | Port read byte, same cycle as `lp_rd` |
| ext_idx_wr | output | 1 | Index-register write strobe |
| ext_idx | output | 4 | Index register contents |
| ext_data_wr | output | 1 | Data-register write at `ext_idx` |
| ext_data_rd | output | 1 | Data-register read at `ext_idx` |
| ext_wdata | output | 16 | Data-register write value |
| ext_rdata | input | 16 | Data-register read value, same cycle as `ext_data_rd` |

## Verification
The bench checks the order of a word write into the port range against the exact strobe log. A design that issued the high byte first would load the data register of an indexed pair before its index. It also checks accesses that run off the end of either range: a four-byte port read at 0x41E and a two-halfword extension access at 0x514. A design that decoded only the start address would touch ports or registers past the range, and the extra log entries or non-zero lanes show this. The other corner cases checked are one-byte extension writes (zero extension), unmapped reads and writes (no strobes, zero data), and a response held under back-pressure. Latency is measured per request, so a skipped or doubled index phase is caught as well.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEG,
    ST_EIDX,
    ST_EDAT,
    ST_RESP
  } seq_st_t;

  // Byte-lane enable mask for an access of len+1 bytes
  function automatic logic [31:0] lane_mask(input logic [1:0] len);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) begin
      m[8*b +: 8] = (2'(b) <= len) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction

endpackage

// File: rtl/disp_win_decode.sv
module disp_win_decode #(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_REGS  = 11,
  parameter int PORT_BASE = 'h3C0,
  parameter int PORT_W    = 10,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] off,
  output logic              in_leg,
  output logic              in_ext,
  output logic [PORT_W-1:0] leg_port,
  output logic [IDX_W-1:0]  ext_index
);
  localparam logic [ADDR_W-1:0] LEG_LO = ADDR_W'(LEG_BASE);
  localparam logic [ADDR_W-1:0] LEG_HI = ADDR_W'(LEG_BASE + LEG_SPAN);
  localparam logic [ADDR_W-1:0] EXT_LO = ADDR_W'(EXT_BASE);
  localparam logic [ADDR_W-1:0] EXT_HI = ADDR_W'(EXT_BASE + 2*EXT_REGS);

  logic [ADDR_W-1:0] rel_leg, rel_ext;

  always_comb begin
    rel_leg   = off - LEG_LO;
    rel_ext   = off - EXT_LO;
    in_leg    = (off >= LEG_LO) && (off < LEG_HI);
    in_ext    = (off >= EXT_LO) && (off < EXT_HI);
    leg_port  = PORT_W'(PORT_BASE) + PORT_W'(rel_leg);
    ext_index = IDX_W'(rel_ext[ADDR_W-1:1]);
  end
endmodule

// File: rtl/disp_win_rdasm.sv
module disp_win_rdasm
  import disp_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        byte_we,
  input  logic [1:0]  byte_lane,
  input  logic [7:0]  byte_d,
  input  logic        half_we,
  input  logic        half_lane,
  input  logic [15:0] half_d,
  input  logic [1:0]  len,
  output logic [31:0] rdata
);
  logic [31:0] lanes;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lanes[8*b +: 8] <= 8'h00;
      end else if (byte_we && byte_lane == 2'(b)) begin
        lanes[8*b +: 8] <= byte_d;
      end else if (half_we && half_lane == 1'(b/2)) begin
        lanes[8*b +: 8] <= half_d[8*(b%2) +: 8];
      end
    end
  end

  assign rdata = lanes & lane_mask(len);
endmodule

// File: rtl/disp_mmio_bridge.sv
module disp_mmio_bridge
  import disp_win_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SPAN  = 'h20,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_REGS  = 11,
  parameter int PORT_BASE = 'h3C0,
  parameter int PORT_W    = 10,
  localparam int IDX_W    = $clog2(EXT_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              lp_wr,
  output logic              lp_rd,
  output logic [PORT_W-1:0] lp_addr,
  output logic [7:0]        lp_wdata,
  input  logic [7:0]        lp_rdata,
  output logic              ext_idx_wr,
  output logic [IDX_W-1:0]  ext_idx,
  output logic              ext_data_wr,
  output logic              ext_data_rd,
  output logic [15:0]       ext_wdata,
  input  logic [15:0]       ext_rdata
);
  seq_st_t           state;
  logic [1:0]        step;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        len_q;
  logic              we_q;
  logic [31:0]       wdata_q;

  logic              accept;
  logic [ADDR_W-1:0] cur_off;
  logic              cur_leg, cur_ext, start_leg, start_ext;
  logic [PORT_W-1:0] cur_port, start_port;
  logic [IDX_W-1:0]  cur_idx, start_idx;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign cur_off   = (state == ST_LEG) ? base_q + ADDR_W'(step)
                                       : base_q + ADDR_W'({step, 1'b0});

  disp_win_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
    .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .PORT_BASE(PORT_BASE),
    .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_dec_cur (
    .off(cur_off), .in_leg(cur_leg), .in_ext(cur_ext),
    .leg_port(cur_port), .ext_index(cur_idx)
  );

  disp_win_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
    .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .PORT_BASE(PORT_BASE),
    .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_dec_req (
    .off(req_addr), .in_leg(start_leg), .in_ext(start_ext),
    .leg_port(start_port), .ext_index(start_idx)
  );

  // Downstream strobes, one sub-operation per cycle
  assign lp_wr       = (state == ST_LEG)  && cur_leg &&  we_q;
  assign lp_rd       = (state == ST_LEG)  && cur_leg && !we_q;
  assign lp_addr     = cur_port;
  assign lp_wdata    = wdata_q[{step, 3'b000} +: 8];
  assign ext_idx_wr  = (state == ST_EIDX) && cur_ext;
  assign ext_data_wr = (state == ST_EDAT) && cur_ext &&  we_q;
  assign ext_data_rd = (state == ST_EDAT) && cur_ext && !we_q;
  assign ext_wdata   = wdata_q[{step[0], 4'b0000} +: 16];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      step    <= '0;
      base_q  <= '0;
      len_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      ext_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          base_q  <= req_addr;
          len_q   <= req_len;
          we_q    <= req_we;
          wdata_q <= req_wdata & lane_mask(req_len);
          step    <= '0;
          if (start_leg)      state <= ST_LEG;
          else if (start_ext) state <= ST_EIDX;
          else                state <= ST_RESP;
        end
        ST_LEG: begin
          if (step == len_q) state <= ST_RESP;
          else               step  <= step + 2'd1;
        end
        ST_EIDX: begin
          if (cur_ext) ext_idx <= cur_idx;
          state <= ST_EDAT;
        end
        ST_EDAT: begin
          if (step[0] == len_q[1]) begin
            state <= ST_RESP;
          end else begin
            step  <= step + 2'd1;
            state <= ST_EIDX;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  disp_win_rdasm u_rdasm (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .byte_we  (lp_rd),
    .byte_lane(step),
    .byte_d   (lp_rdata),
    .half_we  (ext_data_rd),
    .half_lane(step[0]),
    .half_d   (ext_rdata),
    .len      (len_q),
    .rdata    (rsp_rdata)
  );
endmodule

// File: rtl/disp_mmio_bridge_chk.sv
module disp_mmio_bridge_chk #(
  parameter int PORT_BASE = 'h3C0,
  parameter int LEG_SPAN  = 'h20,
  parameter int PORT_W    = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        lp_wr,
  input logic        lp_rd,
  input logic [PORT_W-1:0] lp_addr,
  input logic        ext_idx_wr,
  input logic        ext_data_wr,
  input logic        ext_data_rd
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lp_wr, lp_rd, ext_idx_wr, ext_data_wr, ext_data_rd})); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_NO_READY_IN_RESP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R1

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R1

  AST_IDX_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    ext_idx_wr |=> (ext_data_wr || ext_data_rd)); // R5

  AST_DATA_AFTER_IDX: assert property (@(posedge clk) disable iff (rst)
    (ext_data_wr || ext_data_rd) |-> $past(ext_idx_wr)); // R5

  AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lp_wr || lp_rd) |-> (lp_addr >= PORT_W'(PORT_BASE) &&
                          lp_addr <  PORT_W'(PORT_BASE + LEG_SPAN))); // R2
endmodule

bind disp_mmio_bridge disp_mmio_bridge_chk #(
  .PORT_BASE(PORT_BASE), .LEG_SPAN(LEG_SPAN), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .lp_wr(lp_wr), .lp_rd(lp_rd), .lp_addr(lp_addr),
  .ext_idx_wr(ext_idx_wr), .ext_data_wr(ext_data_wr), .ext_data_rd(ext_data_rd)
);

// File: tb/test_disp_mmio_bridge.sv
module test_disp_mmio_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        lp_wr, lp_rd, ext_idx_wr, ext_data_wr, ext_data_rd;
  logic [9:0]  lp_addr;
  logic [7:0]  lp_wdata, lp_rdata;
  logic [3:0]  ext_idx;
  logic [15:0] ext_wdata, ext_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  disp_mmio_bridge i_disp_mmio_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .lp_wr(lp_wr), .lp_rd(lp_rd), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
    .lp_rdata(lp_rdata), .ext_idx_wr(ext_idx_wr), .ext_idx(ext_idx),
    .ext_data_wr(ext_data_wr), .ext_data_rd(ext_data_rd),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // Downstream device model and strobe log
  logic [7:0]  dev_leg [32];
  logic [15:0] dev_ext [11];
  logic [15:0] act_log [4096];
  logic [11:0] act_n = '0;

  assign lp_rdata  = (lp_addr >= 10'h3C0 && lp_addr < 10'h3E0) ? dev_leg[5'(lp_addr - 10'h3C0)] : 8'h00;
  assign ext_rdata = (ext_idx < 4'd11) ? dev_ext[ext_idx] : 16'h0000;

  function automatic logic [7:0] leg_init(input int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic [15:0] ext_init(input int i);
    return 16'(i * 4111 + 'h1234);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) dev_leg[i] <= leg_init(i);
      for (int i = 0; i < 11; i++) dev_ext[i] <= ext_init(i);
    end else begin
      if (lp_wr) dev_leg[5'(lp_addr - 10'h3C0)] <= lp_wdata;
      if (ext_data_wr && ext_idx < 4'd11) dev_ext[ext_idx] <= ext_wdata;
      if (lp_wr)       begin act_log[act_n] <= {4'd1, 2'b00, lp_addr}; act_n <= act_n + 1'b1; end
      if (lp_rd)       begin act_log[act_n] <= {4'd2, 2'b00, lp_addr}; act_n <= act_n + 1'b1; end
      if (ext_idx_wr)  begin act_log[act_n] <= {4'd3, 12'd0};          act_n <= act_n + 1'b1; end
      if (ext_data_wr) begin act_log[act_n] <= {4'd4, 8'd0, ext_idx};  act_n <= act_n + 1'b1; end
      if (ext_data_rd) begin act_log[act_n] <= {4'd5, 8'd0, ext_idx};  act_n <= act_n + 1'b1; end
    end
  end

  // Reference model
  logic [7:0]  ref_leg [32];
  logic [15:0] ref_ext [11];
  logic [15:0] exp_log [8];
  int          exp_n;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic predict(input logic [11:0] a, input logic [1:0] len, input logic we,
                         input logic [31:0] wd_in, output logic [31:0] rd, output int lat,
                         output string tag);
    logic [31:0] wd;
    logic [11:0] o;
    int idx;
    wd = 32'h0;
    for (int b = 0; b < 4; b++) if (b <= int'(len)) wd[8*b +: 8] = wd_in[8*b +: 8];
    rd = 32'h0;
    exp_n = 0;
    if (a >= 12'h400 && a < 12'h420) begin
      tag = "R3";
      lat = int'(len) + 1;
      for (int k = 0; k <= int'(len); k++) begin
        o = a + 12'(k);
        if (o >= 12'h400 && o < 12'h420) begin
          exp_log[exp_n] = {(we ? 4'd1 : 4'd2), 2'b00, 10'h3C0 + 10'(o - 12'h400)};
          exp_n++;
          if (we) ref_leg[o - 12'h400] = wd[8*k +: 8];
          else    rd[8*k +: 8] = ref_leg[o - 12'h400];
        end
      end
    end else if (a >= 12'h500 && a < 12'h516) begin
      tag = "R5";
      lat = 2 * (int'(len) / 2 + 1);
      for (int h = 0; h <= int'(len) / 2; h++) begin
        o = a + 12'(2 * h);
        if (o >= 12'h500 && o < 12'h516) begin
          idx = int'(o - 12'h500) / 2;
          exp_log[exp_n] = {4'd3, 12'd0}; exp_n++;
          exp_log[exp_n] = {(we ? 4'd4 : 4'd5), 8'd0, 4'(idx)}; exp_n++;
          if (we) ref_ext[idx] = wd[16*h +: 16];
          else    rd[16*h +: 16] = ref_ext[idx];
        end
      end
    end else begin
      tag = "R6";
      lat = 0;
    end
    for (int b = 0; b < 4; b++) if (b > int'(len)) rd[8*b +: 8] = 8'h00;  // R7
  endtask

  task automatic txn(input logic [11:0] a, input logic [1:0] len, input logic we,
                     input logic [31:0] wd);
    logic [31:0] exp_rd, got;
    int exp_lat, lat;
    logic [11:0] base;
    string tag;
    predict(a, len, we, wd, exp_rd, exp_lat, tag);
    @(negedge clk);
    base      = act_n;
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = len;
    req_we    = we;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 ready low while busy", {31'd0, req_ready}, 32'd0);
    lat = 0;
    while (!rsp_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency", 32'(lat), 32'(exp_lat));
    got = rsp_rdata;
    repeat ($urandom % 3) begin
      @(negedge clk);
      check("R1 response held", {rsp_valid, rsp_rdata[30:0]}, {1'b1, got[30:0]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R7 read data"}, got, exp_rd);
    check({tag, " strobe count"}, 32'(act_n - base), 32'(exp_n));
    for (int i = 0; i < exp_n; i++)
      check({tag, " strobe order"}, {16'd0, act_log[12'(base + 12'(i))]}, {16'd0, exp_log[i]});
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 32; i++) ref_leg[i] = leg_init(i);
    for (int i = 0; i < 11; i++) ref_ext[i] = ext_init(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R9 no response", {31'd0, rsp_valid}, 32'd0);
    check("R9 index cleared", {28'd0, ext_idx}, 32'd0);
    check("R9 strobes idle", {27'd0, lp_wr, lp_rd, ext_idx_wr, ext_data_wr, ext_data_rd}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 strobes idle after release", {27'd0, lp_wr, lp_rd, ext_idx_wr, ext_data_wr, ext_data_rd}, 32'd0);

    // Directed corners
    txn(12'h404, 2'd1, 1'b1, 32'h0000_A50B);   // R2 R3 word write, low byte first
    txn(12'h404, 2'd1, 1'b0, 32'h0);           // R3 read back pair
    txn(12'h41E, 2'd3, 1'b0, 32'h0);           // R3 runs past range end
    txn(12'h502, 2'd1, 1'b1, 32'h0000_BEEF);   // R4 R5 index 1
    txn(12'h502, 2'd1, 1'b0, 32'h0);
    txn(12'h514, 2'd3, 1'b0, 32'h0);           // R5 second op outside range
    txn(12'h506, 2'd0, 1'b1, 32'hFFFF_FF77);   // R7 one-byte zero-extended
    txn(12'h506, 2'd1, 1'b0, 32'h0);
    txn(12'h000, 2'd3, 1'b0, 32'h0);           // R6 unmapped read
    txn(12'hFFF, 2'd3, 1'b1, 32'h1234_5678);   // R6 unmapped write
    txn(12'h4FF, 2'd1, 1'b0, 32'h0);           // R6 just below extension range

    // Constrained random
    for (int t = 0; t < 300; t++) begin
      logic [11:0] a;
      int r;
      r = $urandom % 3;
      if (r == 0)      a = 12'h400 + 12'($urandom % 34);
      else if (r == 1) a = 12'h4FE + 12'($urandom % 26);
      else             a = 12'($urandom);
      txn(a, 2'($urandom), 1'($urandom), $urandom);
    end

    @(negedge clk);
    for (int i = 0; i < 32; i++) check("R3 port contents", {24'd0, dev_leg[i]}, {24'd0, ref_leg[i]});
    for (int i = 0; i < 11; i++) check("R5 register contents", {16'd0, dev_ext[i]}, {16'd0, ref_ext[i]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule